// File: doc/BRIEF.md
# Decode Operand Bypass and Stall Unit

This block sits in the decode stage of a five-stage in-order RISC-V pipeline. Each cycle it compares the two source register indices of the instruction in decode with the destinations of the instructions in the execute, memory and writeback stages. For each operand it picks the newest in-flight result for that register, or the register-file read value when no later stage will write the register. The logic is purely combinational, so a forwarded value reaches decode in the same cycle that the producer's result appears on its stage bus.

Two kinds of producer cannot hand their value over from execute: loads and CSR reads. A load's data arrives only in the memory stage, and the CSR unit also sits in the memory stage. When the decoding instruction needs such a producer's result while that producer is still in execute, the unit raises a stall. The stall pulls the decode ready output low, so the instruction in fetch holds. Decode also sends an empty slot (valid low) to execute. One cycle later the producer is in the memory stage and its value is forwarded from there.

Top module: `opnd_bypass_unit`

## Requirements
- R1: When a source index is non-zero and matches the destination of a valid, register-writing instruction in execute, that operand equals the execute result, whatever the other stages hold.
- R2: When a non-zero source matches a writing instruction in memory and does not match one in execute, the operand equals the memory result.
- R3: When a non-zero source matches a writing instruction in writeback and matches none in execute or memory, the operand equals the writeback result.
- R4: When a non-zero source matches no writing instruction in a later stage, the operand equals the register-file input for that operand.
- R5: A source index of 0 always yields an operand of zero. It never causes a stall, even when a stage's destination is also 0.
- R6: A stage whose valid input is low, or whose write-enable is low, takes no part in matching. It affects neither the operands nor the stall.
- R7: When decode is valid and a non-zero source matches a writing load in execute (load flag high), the stall output is 1 and the ready output is 0.
- R8: When decode is valid and a non-zero source matches a writing CSR read in execute (CSR flag high), the stall output is 1 and the ready output is 0.
- R9: A load or CSR read in execute that matches neither non-zero source causes no stall. A producer of either kind that has reached memory is forwarded without a stall.
- R10: The issue-valid output is high exactly when decode is valid and the stall is low. The stall and ready outputs are always complements of each other, and no stall is raised while decode is invalid.
- R11: The second operand follows the same selection rules as the first, independently of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_rs1 | input | RW | First source register index |
| dec_rs2 | input | RW | Second source register index |
| rf_rd1 | input | XW | Register-file value for the first source |
| rf_rd2 | input | XW | Register-file value for the second source |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_rd | input | RW | Execute destination index |
| ex_result | input | XW | Execute result bus |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_csr | input | 1 | Execute instruction is a CSR read |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_rd | input | RW | Memory destination index |
| mem_result | input | XW | Memory result bus (load or CSR data included) |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_rd | input | RW | Writeback destination index |
| wb_result | input | XW | Writeback result bus |
| opnd_a | output | XW | Selected first operand |
| opnd_b | output | XW | Selected second operand |
| dec_stall | output | 1 | Decode must hold this cycle |
| dec_ready | output | 1 | Decode accepts a new instruction from fetch |
| issue_valid | output | 1 | Valid passed from decode to execute |

## Verification
The bench sweeps every combination of stage valid and write-enable bits, load and CSR flags, and decode valid. It also covers every pairing of source and destination indices over registers 0 to 2, so that x0 destinations, several stages matching at once, and gated matches all occur. Three kinds of error show up as wrong operand values: a priority error returns an older stage's value when a newer producer exists, a missing x0 guard returns a bus value instead of zero, and ignoring valid or write-enable forwards stale data. Other faults show up on the stall, ready and issue-valid outputs. A stall test that omits the CSR flag, or ignores which register the producer writes, stalls too little or too often. A stall that is not gated by decode valid drops ready for an empty decode slot.

// File: rtl/opnd_bypass_unit.sv
module opnd_bypass_unit #(
  parameter int XW = 32,
  parameter int RW = 5
) (
  input  logic          dec_valid,
  input  logic [RW-1:0] dec_rs1,
  input  logic [RW-1:0] dec_rs2,
  input  logic [XW-1:0] rf_rd1,
  input  logic [XW-1:0] rf_rd2,
  input  logic          ex_valid,
  input  logic          ex_we,
  input  logic [RW-1:0] ex_rd,
  input  logic [XW-1:0] ex_result,
  input  logic          ex_is_load,
  input  logic          ex_is_csr,
  input  logic          mem_valid,
  input  logic          mem_we,
  input  logic [RW-1:0] mem_rd,
  input  logic [XW-1:0] mem_result,
  input  logic          wb_valid,
  input  logic          wb_we,
  input  logic [RW-1:0] wb_rd,
  input  logic [XW-1:0] wb_result,
  output logic [XW-1:0] opnd_a,
  output logic [XW-1:0] opnd_b,
  output logic          dec_stall,
  output logic          dec_ready,
  output logic          issue_valid
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][RW-1:0] src;
  logic [NSRC-1:0][XW-1:0] rfv;
  logic [NSRC-1:0][XW-1:0] opnd;
  logic [NSRC-1:0]         late_hit;

  assign src = {dec_rs2, dec_rs1};
  assign rfv = {rf_rd2, rf_rd1};

  // a stage is a candidate producer only if it is live, writes, and targets a real register
  logic ex_wr, mem_wr, wb_wr, ex_late;
  assign ex_wr   = ex_valid  & ex_we  & (ex_rd  != '0);
  assign mem_wr  = mem_valid & mem_we & (mem_rd != '0);
  assign wb_wr   = wb_valid  & wb_we  & (wb_rd  != '0);
  assign ex_late = ex_is_load | ex_is_csr;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic zero, h_ex, h_mem, h_wb;
    assign zero  = (src[g] == '0);
    assign h_ex  = ex_wr  & (ex_rd  == src[g]);
    assign h_mem = mem_wr & (mem_rd == src[g]);
    assign h_wb  = wb_wr  & (wb_rd  == src[g]);

    assign opnd[g] = zero  ? '0         :
                     h_ex  ? ex_result  :
                     h_mem ? mem_result :
                     h_wb  ? wb_result  : rfv[g];

    assign late_hit[g] = h_ex & ex_late;
  end

  assign opnd_a      = opnd[0];
  assign opnd_b      = opnd[1];
  assign dec_stall   = dec_valid & (|late_hit);
  assign dec_ready   = ~dec_stall;
  assign issue_valid = dec_valid & ~dec_stall;

endmodule

module opnd_bypass_chk #(
  parameter int XW = 32,
  parameter int RW = 5
) (
  input logic          dec_valid,
  input logic [RW-1:0] dec_rs1,
  input logic [RW-1:0] dec_rs2,
  input logic [XW-1:0] rf_rd1,
  input logic [XW-1:0] rf_rd2,
  input logic          ex_valid,
  input logic          ex_we,
  input logic [RW-1:0] ex_rd,
  input logic [XW-1:0] ex_result,
  input logic          ex_is_load,
  input logic          ex_is_csr,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [RW-1:0] mem_rd,
  input logic [XW-1:0] mem_result,
  input logic          wb_valid,
  input logic          wb_we,
  input logic [RW-1:0] wb_rd,
  input logic [XW-1:0] wb_result,
  input logic [XW-1:0] opnd_a,
  input logic [XW-1:0] opnd_b,
  input logic          dec_stall,
  input logic          dec_ready,
  input logic          issue_valid
);

  always_comb begin
    if (dec_rs1 != '0 && ex_valid && ex_we && ex_rd == dec_rs1)
      a_r1_ex_newest: assert (opnd_a == ex_result);
    if (dec_rs1 == '0)
      a_r5_zero_a: assert (opnd_a == '0);
    if (dec_rs2 == '0)
      a_r5_zero_b: assert (opnd_b == '0);
    if (!ex_valid && !mem_valid && !wb_valid && dec_rs1 != '0)
      a_r6_idle_uses_rf: assert (opnd_a == rf_rd1);
    if (dec_valid && ex_valid && ex_we && ex_is_load && ex_rd != '0 &&
        (ex_rd == dec_rs1 || ex_rd == dec_rs2))
      a_r7_load_holds: assert (!dec_ready);
    if (dec_valid && ex_valid && ex_we && ex_is_csr && ex_rd != '0 &&
        (ex_rd == dec_rs1 || ex_rd == dec_rs2))
      a_r8_csr_holds: assert (dec_stall);
    a_r10_ready_inverse: assert (dec_ready == !dec_stall);
    a_r10_no_issue_in_stall: assert (!(issue_valid && dec_stall));
    if (!dec_valid)
      a_r10_idle_no_stall: assert (!dec_stall && !issue_valid);
  end

endmodule

bind opnd_bypass_unit opnd_bypass_chk #(.XW(XW), .RW(RW)) u_chk (.*);

// File: tb/sim_opnd_bypass_unit.sv
`timescale 1ns/1ps
module sim_opnd_bypass_unit;
  localparam int XW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          dec_valid;
  logic [RW-1:0] dec_rs1, dec_rs2, ex_rd, mem_rd, wb_rd;
  logic [XW-1:0] rf_rd1, rf_rd2, ex_result, mem_result, wb_result;
  logic          ex_valid, ex_we, ex_is_load, ex_is_csr;
  logic          mem_valid, mem_we, wb_valid, wb_we;
  logic [XW-1:0] opnd_a, opnd_b;
  logic          dec_stall, dec_ready, issue_valid;

  opnd_bypass_unit #(.XW(XW), .RW(RW)) u0 (
    .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
    .ex_valid(ex_valid), .ex_we(ex_we), .ex_rd(ex_rd), .ex_result(ex_result),
    .ex_is_load(ex_is_load), .ex_is_csr(ex_is_csr),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_rd(mem_rd), .mem_result(mem_result),
    .wb_valid(wb_valid), .wb_we(wb_we), .wb_rd(wb_rd), .wb_result(wb_result),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dec_stall(dec_stall), .dec_ready(dec_ready), .issue_valid(issue_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not complete, actual cycles=%0d expected <190000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // source codes: 0 zero (R5), 1 execute (R1), 2 memory (R2), 3 writeback (R3), 4 regfile (R4)
  function automatic int pick(input logic [RW-1:0] rs);
    if (rs == 0) return 0;
    if (ex_valid && ex_we && ex_rd == rs) return 1;
    if (mem_valid && mem_we && mem_rd == rs) return 2;
    if (wb_valid && wb_we && wb_rd == rs) return 3;
    return 4;
  endfunction

  function automatic string tag(input int c);
    case (c)
      0: return "R5";
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic bit gated(input logic [RW-1:0] rs);
    return rs != 0 && ((!(ex_valid && ex_we) && ex_rd == rs) ||
                       (!(mem_valid && mem_we) && mem_rd == rs) ||
                       (!(wb_valid && wb_we) && wb_rd == rs));
  endfunction

  task automatic check(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%h expected=%h (rs1=%0d rs2=%0d ex=%0d/%b%b mem=%0d/%b%b wb=%0d/%b%b ld=%b csr=%b dv=%b)",
               req, act, exp, dec_rs1, dec_rs2, ex_rd, ex_valid, ex_we, mem_rd, mem_valid, mem_we,
               wb_rd, wb_valid, wb_we, ex_is_load, ex_is_csr, dec_valid);
    end
  endtask

  function automatic logic [XW-1:0] value_of(input int c, input logic [XW-1:0] rf);
    case (c)
      0: return '0;
      1: return ex_result;
      2: return mem_result;
      3: return wb_result;
      default: return rf;
    endcase
  endfunction

  initial begin
    dec_valid = 0; dec_rs1 = 0; dec_rs2 = 0; rf_rd1 = 0; rf_rd2 = 0;
    ex_valid = 0; ex_we = 0; ex_rd = 0; ex_result = 0; ex_is_load = 0; ex_is_csr = 0;
    mem_valid = 0; mem_we = 0; mem_rd = 0; mem_result = 0;
    wb_valid = 0; wb_we = 0; wb_rd = 0; wb_result = 0;
    #1;
    // quiet state: nothing in flight, decode empty
    check("R10 idle stall", {31'd0, dec_stall}, 0);
    check("R10 idle ready", {31'd0, dec_ready}, 1);
    check("R10 idle issue", {31'd0, issue_valid}, 0);

    for (int r1 = 0; r1 < 3; r1++)
    for (int r2 = 0; r2 < 3; r2++)
    for (int de = 0; de < 3; de++)
    for (int dm = 0; dm < 3; dm++)
    for (int dw = 0; dw < 3; dw++)
    for (int ct = 0; ct < 512; ct++) begin
      logic [8:0] c;
      int ca, cb;
      bit st, late;
      string sreq;
      c = ct[8:0];
      dec_rs1 = RW'(r1); dec_rs2 = RW'(r2);
      ex_rd = RW'(de); mem_rd = RW'(dm); wb_rd = RW'(dw);
      ex_valid = c[0]; ex_we = c[1]; mem_valid = c[2]; mem_we = c[3];
      wb_valid = c[4]; wb_we = c[5]; ex_is_load = c[6]; ex_is_csr = c[7]; dec_valid = c[8];
      rf_rd1 = 32'hF100_0000 + 32'(r1) * 32'h11;
      rf_rd2 = 32'hF200_0000 + 32'(r2) * 32'h11;
      ex_result  = 32'hE000_0000 + 32'(de) * 32'h101 + 32'(ct);
      mem_result = 32'hD000_0000 + 32'(dm) * 32'h101 + 32'(ct) * 3;
      wb_result  = 32'hC000_0000 + 32'(dw) * 32'h101 + 32'(ct) * 7;
      #1;
      ca = pick(dec_rs1);
      cb = pick(dec_rs2);
      late = ex_is_load || ex_is_csr;
      st = dec_valid && late && (ca == 1 || cb == 1);
      check(gated(dec_rs1) ? {tag(ca), "/R6 opnd_a"} : {tag(ca), " opnd_a"}, opnd_a, value_of(ca, rf_rd1));
      check(gated(dec_rs2) ? {tag(cb), "/R6/R11 opnd_b"} : {tag(cb), "/R11 opnd_b"}, opnd_b, value_of(cb, rf_rd2));
      if (st) sreq = ex_is_load ? "R7" : "R8";
      else if (late && dec_valid) sreq = "R9";
      else sreq = "R10";
      check({sreq, " stall"}, {31'd0, dec_stall}, {31'd0, st});
      check({sreq, " ready"}, {31'd0, dec_ready}, {31'd0, !st});
      check("R10 issue_valid", {31'd0, issue_valid}, {31'd0, dec_valid && !st});
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule